// File: doc/BRIEF.md
# HDLC Transmit Command Sequencer

This block decides when a transmit channel sends frames and when it stops. It works through a ring of transmit descriptors. While the channel is active, it checks the ready bit of the current descriptor at a fixed interval. It checks sooner when the on-demand input asks for it. When it finds a ready descriptor, it pulses a start strobe to the serializer. When the serializer reports the frame complete, the pointer moves to the next descriptor.

Three commands change this flow: stop, graceful stop and restart.

- **Stop:** if no frame is in progress, polling simply halts. If a frame is in progress, the frame is cut off after a bounded number of serial bit periods. The FIFO is flushed, an abort sequence is requested, and the descriptor pointer stays where it was.
- **Graceful stop:** the frame in progress is allowed to finish. The pointer then advances and a sticky graceful-stop event is raised.
- **Restart:** this is the only command accepted once the channel has halted. It can follow a stop, a graceful stop or a transmit error. Polling resumes from the current descriptor.

Whenever the line is not carrying a frame, it carries either flags or all ones, selected by a configuration input.

Top module: `hdlc_tx_cmd_seq`

## Requirements
- R1: During and right after reset, `desc_ptr` is 0, `frame_start`, `fifo_flush`, `abort_req` and `gs_event` are 0, and `line_mode` is 0.
- R2: While polling with `chan_en` high, the ready bit is sampled every POLL_PERIOD clocks, counted from reset release or from the cycle that polling resumed. `frame_start` rises on the POLL_PERIOD-th clock edge after that point if `desc_ready` is high then. A descriptor that becomes ready between polls is only seen at the next poll.
- R3: With `on_demand` high while polling, the ready bit is sampled on every clock, so `frame_start` rises on the first edge.
- R4: When `frame_done` is seen during a normal frame, `desc_ptr` increments by one, wrapping from RING-1 to 0, and polling restarts its interval.
- R5: A stop command (`cmd_op`=1) while polling halts the channel. No `frame_start` follows even with `desc_ready` high, and `desc_ptr` is unchanged.
- R6: A stop command during a frame counts `bit_tick` pulses. On the ABORT_BITS-th pulse, `fifo_flush` and `abort_req` pulse for one cycle, with `line_mode`=3 in that cycle. `desc_ptr` stays unadvanced and the channel halts.
- R7: A graceful-stop command (`cmd_op`=2) during a frame waits for `frame_done`. It then advances `desc_ptr`, sets `gs_event` and halts.
- R8: A graceful-stop command while polling halts at once and sets `gs_event`, with `desc_ptr` unchanged.
- R9: A restart command (`cmd_op`=3) after a stop, a graceful stop or a transmit error resumes polling from the current `desc_ptr`. The first poll comes POLL_PERIOD clocks later.
- R10: `tx_error` during a frame halts the channel without advancing `desc_ptr`.
- R11: While halted, stop and graceful-stop commands are ignored: `gs_event` stays clear and no frame starts. A restart command during an active frame is ignored.
- R12: `line_mode` encodes the line: 0 = idle ones, 1 = idle flags, 2 = frame, 3 = abort. When no frame is in progress, `cfg_idle_flags` selects 1 (flags) or 0 (ones), one clock after it changes.
- R13: `gs_event` stays set until a `gs_clr` strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; polling runs only while high |
| on_demand | input | 1 | Poll on every clock instead of at the interval |
| cfg_idle_flags | input | 1 | Idle fill: 1 = flags, 0 = ones |
| cmd_op | input | 2 | Command: 0 none, 1 stop, 2 graceful stop, 3 restart |
| desc_ready | input | 1 | Ready bit of the descriptor at `desc_ptr` |
| frame_done | input | 1 | Serializer finished the current frame |
| bit_tick | input | 1 | One pulse per serial bit sent |
| tx_error | input | 1 | Transmit error during a frame |
| gs_clr | input | 1 | Write-one-to-clear strobe for `gs_event` |
| desc_ptr | output | clog2(RING) | Current descriptor index |
| frame_start | output | 1 | One-cycle strobe: start sending the current descriptor |
| fifo_flush | output | 1 | One-cycle strobe: flush the transmit FIFO |
| abort_req | output | 1 | One-cycle strobe: send the abort pattern |
| gs_event | output | 1 | Sticky graceful-stop event |
| line_mode | output | 2 | Line content encoding (see R12) |

## Verification
The poll latency is measured for three cases:

- a ready descriptor on every frame over a full ring wrap;
- a descriptor that turns ready between polls;
- on-demand polling.

Together these separate an interval off by one, a timer that is not restarted, and polling that ignores the on-demand input.

The abort path is swept with bit ticks every 1, 2 and 3 clocks. The expected abort cycle is the product of spacing and count, so a counter that counts clocks instead of bits is caught.

Stop, graceful stop and error are each tried inside and outside a frame. Each case is followed by a long idle window with a ready descriptor and then a restart, which tells "pointer held" from "pointer advanced" and shows whether a halt actually holds.

// File: rtl/hdlc_txseq_pkg.sv
package hdlc_txseq_pkg;

  typedef enum logic [2:0] {
    ST_POLL  = 3'd0,
    ST_SEND  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_HALT  = 3'd3,
    ST_GHALT = 3'd4,
    ST_EHALT = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_STOP    = 2'd1,
    OP_GRACE   = 2'd2,
    OP_RESTART = 2'd3
  } txcmd_e;

  typedef enum logic [1:0] {
    LN_ONES  = 2'd0,
    LN_FLAGS = 2'd1,
    LN_FRAME = 2'd2,
    LN_ABORT = 2'd3
  } line_e;

endpackage

// File: rtl/hdlc_txseq_poll_timer.sv
module hdlc_txseq_poll_timer #(
  parameter int POLL_PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic on_demand,
  output logic poll
);
  localparam int CW = $clog2(POLL_PERIOD);
  localparam logic [CW-1:0] TOP = CW'(POLL_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign poll = run && (on_demand || cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run || poll) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R2: the interval counter never passes its terminal value
  p_poll_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  // R2: while running without a poll, the count moves forward by one
  p_poll_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !poll) |=> (cnt_q != '0));
endmodule

// File: rtl/hdlc_txseq_abort_cnt.sv
module hdlc_txseq_abort_cnt #(
  parameter int ABORT_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_tick,
  output logic due
);
  localparam int CW = $clog2(ABORT_BITS);
  localparam logic [CW-1:0] LAST = CW'(ABORT_BITS - 1);

  logic [CW-1:0] cnt_q;

  assign due = run && bit_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (bit_tick) cnt_q <= cnt_q + 1'b1;
  end

  // R6: the drain never runs past the configured bit budget
  p_drain_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R6: the count only moves on a serial bit
  p_drain_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !bit_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/hdlc_txseq_ring.sv
module hdlc_txseq_ring #(
  parameter int RING = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(RING)-1:0] ptr
);
  localparam int PW = $clog2(RING);
  localparam logic [PW-1:0] LAST = PW'(RING - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // R4: the pointer stays inside the ring
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);
endmodule

// File: rtl/hdlc_tx_cmd_seq.sv
module hdlc_tx_cmd_seq
  import hdlc_txseq_pkg::*;
#(
  parameter int RING        = 8,
  parameter int POLL_PERIOD = 64,
  parameter int ABORT_BITS  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chan_en,
  input  logic                    on_demand,
  input  logic                    cfg_idle_flags,
  input  logic [1:0]              cmd_op,
  input  logic                    desc_ready,
  input  logic                    frame_done,
  input  logic                    bit_tick,
  input  logic                    tx_error,
  input  logic                    gs_clr,
  output logic [$clog2(RING)-1:0] desc_ptr,
  output logic                    frame_start,
  output logic                    fifo_flush,
  output logic                    abort_req,
  output logic                    gs_event,
  output logic [1:0]              line_mode
);

  seq_state_e state_q, state_d;
  txcmd_e     op;
  logic       gs_pend_q, gs_pend_d;
  logic       poll, abort_due, adv;
  logic       start_d, abort_d, gs_set;
  line_e      line_d;

  assign op = txcmd_e'(cmd_op);

  hdlc_txseq_poll_timer #(.POLL_PERIOD(POLL_PERIOD)) u_poll (
    .clk       (clk),
    .rst       (rst),
    .run       (state_q == ST_POLL && chan_en),
    .on_demand (on_demand),
    .poll      (poll)
  );

  hdlc_txseq_abort_cnt #(.ABORT_BITS(ABORT_BITS)) u_drain (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q == ST_DRAIN),
    .bit_tick (bit_tick),
    .due      (abort_due)
  );

  hdlc_txseq_ring #(.RING(RING)) u_ring (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .ptr (desc_ptr)
  );

  always_comb begin
    state_d   = state_q;
    gs_pend_d = gs_pend_q;
    start_d   = 1'b0;
    abort_d   = 1'b0;
    adv       = 1'b0;
    gs_set    = 1'b0;
    unique case (state_q)
      ST_POLL: begin
        if (op == OP_STOP) begin
          state_d = ST_HALT;
        end else if (op == OP_GRACE) begin
          state_d = ST_GHALT;
          gs_set  = 1'b1;
        end else if (poll && desc_ready) begin
          state_d   = ST_SEND;
          start_d   = 1'b1;
          gs_pend_d = 1'b0;
        end
      end
      ST_SEND: begin
        if (frame_done) begin
          adv = 1'b1;
          if (op == OP_STOP) begin
            state_d = ST_HALT;
          end else if (gs_pend_q || op == OP_GRACE) begin
            state_d = ST_GHALT;
            gs_set  = 1'b1;
          end else begin
            state_d = ST_POLL;
          end
        end else if (tx_error) begin
          state_d = ST_EHALT;
        end else if (op == OP_STOP) begin
          state_d = ST_DRAIN;
        end else if (op == OP_GRACE) begin
          gs_pend_d = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (abort_due) begin
          state_d = ST_HALT;
          abort_d = 1'b1;
        end
      end
      ST_HALT, ST_GHALT, ST_EHALT: begin
        if (op == OP_RESTART) state_d = ST_POLL;
      end
      default: state_d = ST_POLL;
    endcase
  end

  always_comb begin
    if (abort_d)                                    line_d = LN_ABORT;
    else if (state_d == ST_SEND || state_d == ST_DRAIN) line_d = LN_FRAME;
    else if (cfg_idle_flags)                        line_d = LN_FLAGS;
    else                                            line_d = LN_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_POLL;
      gs_pend_q   <= 1'b0;
      frame_start <= 1'b0;
      fifo_flush  <= 1'b0;
      abort_req   <= 1'b0;
      gs_event    <= 1'b0;
      line_mode   <= LN_ONES;
    end else begin
      state_q     <= state_d;
      gs_pend_q   <= gs_pend_d;
      frame_start <= start_d;
      fifo_flush  <= abort_d;
      abort_req   <= abort_d;
      line_mode   <= line_d;
      if (gs_set)      gs_event <= 1'b1;
      else if (gs_clr) gs_event <= 1'b0;
    end
  end

  // R6: an abort request always comes with a flush and the abort line code
  p_abort_flush_r6: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> (fifo_flush && line_mode == LN_ABORT));

  // R6: the pointer never moves while a frame is being drained
  p_drain_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |=> $stable(desc_ptr));

  // R13: the graceful event holds until cleared
  p_gs_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    (gs_event && !gs_clr) |=> gs_event);

  // R2: a frame only starts on a ready descriptor
  p_start_ready_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(desc_ready));

  // R11: a halted channel starts nothing without a restart
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && op != OP_RESTART) |=> !frame_start);

  // R6: start and abort strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start, abort_req}));
endmodule

// File: tb/sim_hdlc_tx_cmd_seq.sv
module sim_hdlc_tx_cmd_seq;
  localparam int RING = 3;
  localparam int P    = 8;
  localparam int AB   = 4;

  logic clk = 1'b0;
  logic rst, chan_en, on_demand, cfg_idle_flags, desc_ready;
  logic frame_done, bit_tick, tx_error, gs_clr;
  logic [1:0] cmd_op;
  logic [1:0] desc_ptr;
  logic frame_start, fifo_flush, abort_req, gs_event;
  logic [1:0] line_mode;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hdlc_tx_cmd_seq #(.RING(RING), .POLL_PERIOD(P), .ABORT_BITS(AB)) u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .on_demand(on_demand),
    .cfg_idle_flags(cfg_idle_flags), .cmd_op(cmd_op), .desc_ready(desc_ready),
    .frame_done(frame_done), .bit_tick(bit_tick), .tx_error(tx_error),
    .gs_clr(gs_clr), .desc_ptr(desc_ptr), .frame_start(frame_start),
    .fifo_flush(fifo_flush), .abort_req(abort_req), .gs_event(gs_event),
    .line_mode(line_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int n, output bit found, input int lim);
    n = 0;
    found = 1'b0;
    while (n < lim && !found) begin
      @(negedge clk);
      n++;
      found = frame_start;
    end
  endtask

  task automatic pulse_cmd(input logic [1:0] op);
    cmd_op = op;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic finish_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic run_all();
    int n;
    bit found;
    int ptr;
    rst = 1'b1; chan_en = 1'b1; on_demand = 1'b0; cfg_idle_flags = 1'b1;
    desc_ready = 1'b1; frame_done = 1'b0; bit_tick = 1'b0; tx_error = 1'b0;
    gs_clr = 1'b0; cmd_op = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", desc_ptr, 0);
    chk("R1 strobes", {frame_start, fifo_flush, abort_req, gs_event}, 0);
    chk("R1 line", line_mode, 0);
    rst = 1'b0;
    wait_start(n, found, 4 * P);
    chk("R2 first poll latency", n, P);
    // R4 ring walk over a full wrap, R2 interval each time
    for (int i = 0; i <= RING; i++) begin
      chk("R4 ptr before frame", desc_ptr, i % RING);
      chk("R12 frame line", line_mode, 2);
      finish_frame();
      chk("R4 ptr after frame", desc_ptr, (i + 1) % RING);
      chk("R12 flag fill", line_mode, 1);
      wait_start(n, found, 4 * P);
      chk("R2 poll latency", n, P);
    end
    // R3 on-demand poll
    on_demand = 1'b1;
    finish_frame();
    wait_start(n, found, 4 * P);
    chk("R3 on-demand latency", n, 1);
    on_demand = 1'b0;
    // R6 stop in frame, swept over bit spacing
    for (int k = 1; k <= 3; k++) begin
      ptr = desc_ptr;
      pulse_cmd(2'd1);
      n = 0;
      for (int j = 1; j <= 64; j++) begin
        bit_tick = ((j % k) == 0);
        @(negedge clk);
        if (abort_req) begin
          n = j;
          chk("R6 flush with abort", fifo_flush, 1);
          chk("R6 abort line", line_mode, 3);
          break;
        end
      end
      bit_tick = 1'b0;
      chk("R6 abort cycle", n, AB * k);
      chk("R6 ptr held", desc_ptr, ptr);
      @(negedge clk);
      chk("R6 one-cycle abort", {abort_req, fifo_flush}, 0);
      chk("R12 fill after abort", line_mode, 1);
      wait_start(n, found, 3 * P);
      chk("R6 halted after abort", found, 0);
      pulse_cmd(2'd2);
      chk("R11 grace ignored when halted", gs_event, 0);
      pulse_cmd(2'd3);
      wait_start(n, found, 4 * P);
      chk("R9 restart latency", n, P);
      chk("R9 resume same ptr", desc_ptr, ptr);
    end
    // R5 stop while polling
    finish_frame();
    ptr = desc_ptr;
    pulse_cmd(2'd1);
    wait_start(n, found, 3 * P);
    chk("R5 idle stop halts", found, 0);
    chk("R5 ptr unchanged", desc_ptr, ptr);
    cfg_idle_flags = 1'b0;
    @(negedge clk);
    chk("R12 ones fill", line_mode, 0);
    cfg_idle_flags = 1'b1;
    @(negedge clk);
    chk("R12 flags fill", line_mode, 1);
    pulse_cmd(2'd3);
    wait_start(n, found, 4 * P);
    chk("R9 restart after idle stop", n, P);
    // R7 graceful stop in frame
    ptr = desc_ptr;
    pulse_cmd(2'd2);
    repeat (3) @(negedge clk);
    chk("R7 waits for frame end", gs_event, 0);
    chk("R7 frame still on line", line_mode, 2);
    finish_frame();
    chk("R7 event", gs_event, 1);
    chk("R7 ptr advanced", desc_ptr, (ptr + 1) % RING);
    wait_start(n, found, 3 * P);
    chk("R7 halted", found, 0);
    pulse_cmd(2'd1);
    chk("R11 stop ignored when halted", abort_req, 0);
    repeat (4) @(negedge clk);
    chk("R13 event sticky", gs_event, 1);
    gs_clr = 1'b1;
    @(negedge clk);
    gs_clr = 1'b0;
    chk("R13 event cleared", gs_event, 0);
    pulse_cmd(2'd3);
    wait_start(n, found, 4 * P);
    chk("R9 restart after graceful", n, P);
    chk("R9 ptr after graceful", desc_ptr, (ptr + 1) % RING);
    // R8 graceful stop while polling
    finish_frame();
    ptr = desc_ptr;
    pulse_cmd(2'd2);
    chk("R8 immediate event", gs_event, 1);
    wait_start(n, found, 3 * P);
    chk("R8 halted", found, 0);
    chk("R8 ptr unchanged", desc_ptr, ptr);
    gs_clr = 1'b1;
    @(negedge clk);
    gs_clr = 1'b0;
    pulse_cmd(2'd3);
    wait_start(n, found, 4 * P);
    chk("R9 restart after idle graceful", n, P);
    // R10 transmit error
    ptr = desc_ptr;
    tx_error = 1'b1;
    @(negedge clk);
    tx_error = 1'b0;
    chk("R10 ptr held", desc_ptr, ptr);
    wait_start(n, found, 3 * P);
    chk("R10 halted", found, 0);
    pulse_cmd(2'd3);
    wait_start(n, found, 4 * P);
    chk("R9 restart after error", n, P);
    chk("R9 ptr after error", desc_ptr, ptr);
    // R11 restart during frame ignored
    pulse_cmd(2'd3);
    chk("R11 restart in frame ignored", line_mode, 2);
    finish_frame();
    chk("R11 normal advance", desc_ptr, (ptr + 1) % RING);
    // R2 descriptor ready between polls
    desc_ready = 1'b0;
    n = 0;
    found = 1'b0;
    while (n < 5 * P && !found) begin
      if (n == 2 * P + 2) desc_ready = 1'b1;
      @(negedge clk);
      n++;
      found = frame_start;
    end
    chk("R2 late ready waits for next poll", n, 3 * P);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 4);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule